// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block decides, for each of the two ALU operands of the instruction about to execute in a five-stage in-order pipeline, where the operand value should come from. It can come from the register file read made at decode. It can also come from the result held one stage ahead in the memory stage, or from the value about to be written back one stage further on. The decision compares the two source register numbers of the executing instruction with the destination register numbers and write enables of the two older instructions still in flight.

The block is purely combinational. It drives a 2-bit select per operand and also applies those selects to a pair of operand multiplexers, so the execute stage receives ready operands. Writes to register zero are never bypassed, because that register always reads as zero. Instructions that do not write a register are never bypassed either. When both older instructions target the same source register, the younger one, in the memory stage, supplies the value.

Top module: `fwd_bypass_unit`

## Requirements
- R1: `sel_a` is 2'b10 (memory-stage result) whenever `mem_wen` is 1, `mem_rd` is non-zero and `mem_rd` equals `ex_rs1`; `op_a` then equals `mem_alu_result`.
- R2: `sel_b` is 2'b10 whenever `mem_wen` is 1, `mem_rd` is non-zero and `mem_rd` equals `ex_rs2`; `op_b` then equals `mem_alu_result`.
- R3: When R1 does not apply, `sel_a` is 2'b01 (write-back value) whenever `wb_wen` is 1, `wb_rd` is non-zero and `wb_rd` equals `ex_rs1`.
- R4: When R2 does not apply, `sel_b` is 2'b01 whenever `wb_wen` is 1, `wb_rd` is non-zero and `wb_rd` equals `ex_rs2`.
- R5: When both the memory stage and the write-back stage match the same source, the select is 2'b10 and the memory-stage result is used.
- R6: A destination of register 0 never causes bypassing, whatever the write enable and the source number.
- R7: A stage whose write enable is 0 never causes bypassing, whatever its destination number.
- R8: With no qualifying match, the select is 2'b00 and the operand equals the register file value (`rf_a` for A, `rf_b` for B).
- R9: The write-back value is `wb_load_data` when `wb_mem2reg` is 1 and `wb_alu_result` when it is 0.
- R10: The two operands are resolved independently; each operand output equals the source named by its own select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs1 | input | 5 | First source register number of the executing instruction |
| ex_rs2 | input | 5 | Second source register number of the executing instruction |
| rf_a | input | 32 | Register file value read for the first source |
| rf_b | input | 32 | Register file value read for the second source |
| mem_rd | input | 5 | Destination register number in the memory stage |
| mem_wen | input | 1 | Register-write enable in the memory stage |
| mem_alu_result | input | 32 | ALU result held in the memory stage |
| wb_rd | input | 5 | Destination register number in the write-back stage |
| wb_wen | input | 1 | Register-write enable in the write-back stage |
| wb_mem2reg | input | 1 | Write-back takes loaded data (1) or the ALU result (0) |
| wb_load_data | input | 32 | Data loaded from memory, held in the write-back stage |
| wb_alu_result | input | 32 | ALU result held in the write-back stage |
| sel_a | output | 2 | Source select for operand A (00 file, 01 write-back, 10 memory stage) |
| sel_b | output | 2 | Source select for operand B, same encoding |
| op_a | output | 32 | Resolved operand A |
| op_b | output | 32 | Resolved operand B |

## Verification
Two functions can fall in the same evaluation: a memory-stage bypass and a write-back bypass aimed at the same source, and the same producer feeding both operands at once. The bench provokes both by setting both destinations equal to one source, or by setting both sources equal to one destination. It then sweeps every mix of write enables and of matching, non-matching and zero destinations. Each select and operand is compared with the value that the priority rule predicts, with distinct data words on every path so that a wrong choice shows up.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  // Operand source encoding shared by the selector and the operand mux.
  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_WB  = 2'b01,
    SEL_MEM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] dst,
  input  logic             wen,
  output logic             hit
);
  logic dst_nonzero;
  logic same_reg;

  always_comb begin
    dst_nonzero = |dst;
    same_reg    = (dst == src);
    hit         = wen && dst_nonzero && same_reg;
  end
endmodule

// File: rtl/fwd_select.sv
module fwd_select
  import fwd_pkg::*;
(
  input  logic     hit_mem,
  input  logic     hit_wb,
  output fwd_sel_e sel
);
  always_comb begin
    if (hit_mem)     sel = SEL_MEM;
    else if (hit_wb) sel = SEL_WB;
    else             sel = SEL_RF;
  end

  always_comb begin
    if (hit_mem) begin
      // R5
      younger_wins_chk: assert (sel == SEL_MEM) else $error("memory-stage hit not selected");
    end
    if (hit_wb && !hit_mem) begin
      // R3
      wb_taken_chk: assert (sel == SEL_WB) else $error("write-back hit not selected");
    end
    if (!hit_mem && !hit_wb) begin
      // R8
      idle_file_chk: assert (sel == SEL_RF) else $error("bypass without hit");
    end
  end
endmodule

// File: rtl/fwd_wb_value.sv
module fwd_wb_value #(
  parameter int DATA_W = 32
) (
  input  logic              mem2reg,
  input  logic [DATA_W-1:0] load_data,
  input  logic [DATA_W-1:0] alu_result,
  output logic [DATA_W-1:0] value
);
  always_comb begin
    value = mem2reg ? load_data : alu_result;
  end
endmodule

// File: rtl/fwd_operand_mux.sv
module fwd_operand_mux
  import fwd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  fwd_sel_e          sel,
  input  logic [DATA_W-1:0] rf_val,
  input  logic [DATA_W-1:0] mem_val,
  input  logic [DATA_W-1:0] wb_val,
  output logic [DATA_W-1:0] op
);
  always_comb begin
    case (sel)
      SEL_MEM: op = mem_val;
      SEL_WB:  op = wb_val;
      default: op = rf_val;
    endcase
  end
endmodule

// File: rtl/fwd_bypass_unit.sv
module fwd_bypass_unit
  import fwd_pkg::*;
#(
  parameter int REG_W   = 5,
  parameter int DATA_W  = 32
) (
  input  logic [REG_W-1:0]  ex_rs1,
  input  logic [REG_W-1:0]  ex_rs2,
  input  logic [DATA_W-1:0] rf_a,
  input  logic [DATA_W-1:0] rf_b,
  input  logic [REG_W-1:0]  mem_rd,
  input  logic              mem_wen,
  input  logic [DATA_W-1:0] mem_alu_result,
  input  logic [REG_W-1:0]  wb_rd,
  input  logic              wb_wen,
  input  logic              wb_mem2reg,
  input  logic [DATA_W-1:0] wb_load_data,
  input  logic [DATA_W-1:0] wb_alu_result,
  output logic [1:0]        sel_a,
  output logic [1:0]        sel_b,
  output logic [DATA_W-1:0] op_a,
  output logic [DATA_W-1:0] op_b
);
  localparam int NUM_SRC = 2;

  logic [REG_W-1:0]  src_num [NUM_SRC];
  logic [DATA_W-1:0] src_rf  [NUM_SRC];
  logic [DATA_W-1:0] src_op  [NUM_SRC];
  fwd_sel_e          src_sel [NUM_SRC];
  logic [DATA_W-1:0] wb_value;

  assign src_num[0] = ex_rs1;
  assign src_num[1] = ex_rs2;
  assign src_rf[0]  = rf_a;
  assign src_rf[1]  = rf_b;

  // R9: value presented by the write-back stage
  fwd_wb_value #(.DATA_W(DATA_W)) u_wb_value (
    .mem2reg   (wb_mem2reg),
    .load_data (wb_load_data),
    .alu_result(wb_alu_result),
    .value     (wb_value)
  );

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    logic hit_mem;
    logic hit_wb;

    fwd_match #(.REG_W(REG_W)) u_match_mem (
      .src(src_num[s]), .dst(mem_rd), .wen(mem_wen), .hit(hit_mem)
    );
    fwd_match #(.REG_W(REG_W)) u_match_wb (
      .src(src_num[s]), .dst(wb_rd), .wen(wb_wen), .hit(hit_wb)
    );
    fwd_select u_select (
      .hit_mem(hit_mem), .hit_wb(hit_wb), .sel(src_sel[s])
    );
    fwd_operand_mux #(.DATA_W(DATA_W)) u_mux (
      .sel(src_sel[s]), .rf_val(src_rf[s]), .mem_val(mem_alu_result),
      .wb_val(wb_value), .op(src_op[s])
    );
  end

  assign sel_a = src_sel[0];
  assign sel_b = src_sel[1];
  assign op_a  = src_op[0];
  assign op_b  = src_op[1];

  always_comb begin
    if (mem_rd == '0) begin
      // R6
      mem_zero_chk: assert (sel_a != 2'b10 && sel_b != 2'b10) else $error("bypass from r0 in memory stage");
    end
    if (wb_rd == '0) begin
      // R6
      wb_zero_chk: assert (sel_a != 2'b01 && sel_b != 2'b01) else $error("bypass from r0 in write-back");
    end
    if (!mem_wen && !wb_wen) begin
      // R7
      no_writer_chk: assert (sel_a == 2'b00 && sel_b == 2'b00) else $error("bypass with no writer");
    end
    if (mem_wen && mem_rd != '0 && mem_rd == ex_rs1) begin
      // R1
      mem_to_a_chk: assert (op_a == mem_alu_result) else $error("operand A missed memory-stage value");
    end
    if (mem_wen && mem_rd != '0 && mem_rd == ex_rs2) begin
      // R2
      mem_to_b_chk: assert (op_b == mem_alu_result) else $error("operand B missed memory-stage value");
    end
  end
endmodule

// File: tb/fwd_bypass_unit_test.sv
module fwd_bypass_unit_test;
  logic        clk = 1'b0;
  logic [4:0]  ex_rs1, ex_rs2, mem_rd, wb_rd;
  logic [31:0] rf_a, rf_b, mem_alu_result, wb_load_data, wb_alu_result;
  logic        mem_wen, wb_wen, wb_mem2reg;
  logic [1:0]  sel_a, sel_b;
  logic [31:0] op_a, op_b;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;

  always #4 clk = ~clk; // 125 MHz

  fwd_bypass_unit uut (
    .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .rf_a(rf_a), .rf_b(rf_b),
    .mem_rd(mem_rd), .mem_wen(mem_wen), .mem_alu_result(mem_alu_result),
    .wb_rd(wb_rd), .wb_wen(wb_wen), .wb_mem2reg(wb_mem2reg),
    .wb_load_data(wb_load_data), .wb_alu_result(wb_alu_result),
    .sel_a(sel_a), .sel_b(sel_b), .op_a(op_a), .op_b(op_b)
  );

  function automatic logic [1:0] exp_sel(logic [4:0] src);
    if (mem_wen && mem_rd != 5'd0 && mem_rd == src) return 2'b10;
    if (wb_wen && wb_rd != 5'd0 && wb_rd == src)    return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [31:0] exp_op(logic [1:0] s, logic [31:0] rf);
    case (s)
      2'b10:   return mem_alu_result;
      2'b01:   return wb_mem2reg ? wb_load_data : wb_alu_result;
      default: return rf;
    endcase
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Apply one set of stage inputs and compare everything at the ports.
  task automatic drive_and_check(string req,
      logic [4:0] rs1, logic [4:0] rs2,
      logic [4:0] mrd, logic mw, logic [4:0] wrd, logic ww, logic m2r);
    logic [1:0] ea, eb;
    @(negedge clk);
    ex_rs1 = rs1; ex_rs2 = rs2; mem_rd = mrd; mem_wen = mw;
    wb_rd = wrd; wb_wen = ww; wb_mem2reg = m2r;
    #1;
    ea = exp_sel(rs1);
    eb = exp_sel(rs2);
    check(req, "sel_a", {30'd0, sel_a}, {30'd0, ea});
    check(req, "sel_b", {30'd0, sel_b}, {30'd0, eb});
    check(req, "op_a", op_a, exp_op(ea, rf_a));
    check(req, "op_b", op_b, exp_op(eb, rf_b));
  endtask

  task automatic t_idle;      // R8 R7: nothing writing, file values pass
    drive_and_check("R8", 5'd3, 5'd5, 5'd3, 1'b0, 5'd5, 1'b0, 1'b0);
    check("R8", "idle sel_a", {30'd0, sel_a}, 32'd0);
    check("R8", "idle op_b", op_b, rf_b);
  endtask

  task automatic t_mem_only;  // R1 R2
    drive_and_check("R1", 5'd7, 5'd9, 5'd7, 1'b1, 5'd0, 1'b0, 1'b0);
    check("R1", "op_a mem", op_a, mem_alu_result);
    drive_and_check("R2", 5'd7, 5'd9, 5'd9, 1'b1, 5'd0, 1'b0, 1'b0);
    check("R2", "op_b mem", op_b, mem_alu_result);
  endtask

  task automatic t_wb_only;   // R3 R4 R9
    drive_and_check("R3", 5'd12, 5'd13, 5'd1, 1'b1, 5'd12, 1'b1, 1'b0);
    check("R9", "op_a wb alu", op_a, wb_alu_result);
    drive_and_check("R4", 5'd12, 5'd13, 5'd1, 1'b0, 5'd13, 1'b1, 1'b1);
    check("R9", "op_b wb load", op_b, wb_load_data);
  endtask

  task automatic t_both;      // R5 R10: younger wins, both operands from one producer
    drive_and_check("R5", 5'd4, 5'd8, 5'd4, 1'b1, 5'd4, 1'b1, 1'b1);
    check("R5", "sel_a both", {30'd0, sel_a}, 32'd2);
    drive_and_check("R10", 5'd6, 5'd6, 5'd6, 1'b1, 5'd2, 1'b1, 1'b0);
    check("R10", "op_b same src", op_b, mem_alu_result);
    drive_and_check("R10", 5'd6, 5'd2, 5'd6, 1'b1, 5'd2, 1'b1, 1'b1);
    check("R10", "op_b split", op_b, wb_load_data);
  endtask

  task automatic t_zero;      // R6
    drive_and_check("R6", 5'd0, 5'd0, 5'd0, 1'b1, 5'd0, 1'b1, 1'b1);
    check("R6", "op_a r0", op_a, rf_a);
    check("R6", "op_b r0", op_b, rf_b);
  endtask

  task automatic t_wen_off;   // R7
    drive_and_check("R7", 5'd10, 5'd11, 5'd10, 1'b0, 5'd11, 1'b0, 1'b0);
    check("R7", "op_a no wen", op_a, rf_a);
    check("R7", "op_b no wen", op_b, rf_b);
  endtask

  task automatic t_sweep;     // R10 with R1..R7: every match combination
    logic [4:0] regs [3];
    regs[0] = 5'd0; regs[1] = 5'd3; regs[2] = 5'd5;
    for (int mw = 0; mw < 2; mw++)
      for (int ww = 0; ww < 2; ww++)
        for (int mi = 0; mi < 3; mi++)
          for (int wi = 0; wi < 3; wi++)
            for (int m2r = 0; m2r < 2; m2r++)
              drive_and_check("R10", 5'd3, 5'd5, regs[mi], mw[0], regs[wi], ww[0], m2r[0]);
  endtask

  initial begin
    ex_rs1 = '0; ex_rs2 = '0; mem_rd = '0; wb_rd = '0;
    mem_wen = 1'b0; wb_wen = 1'b0; wb_mem2reg = 1'b0;
    rf_a = 32'h1111_0001; rf_b = 32'h2222_0002;
    mem_alu_result = 32'hAAAA_000A; wb_alu_result = 32'hBBBB_000B;
    wb_load_data = 32'hCCCC_000C;
    t_idle();
    t_mem_only();
    t_wb_only();
    t_both();
    t_zero();
    t_wen_off();
    t_sweep();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule